// File: doc/BRIEF.md
# Configurable UART Receiver with Error Tagging

This block receives asynchronous serial characters on a single line. It samples the line on a clock enable that runs at sixteen times the bit rate. Data is sent least significant bit first. The frame format is chosen at run time from a mode byte, which selects 7 or 8 data bits, parity off, even or odd, and one or two stop bits. Each finished character is written, together with its own parity and framing error tags, into a sixteen-entry first-in first-out store. The consumer reads that store from the head with a pop strobe.

Several conditions are reported at the ports. A one-cycle pulse marks a character that was lost because the store was full. Another one-cycle pulse marks a break, which is a line held low for a whole frame. A threshold flag shows that the fill count has reached a programmable level. A data-ready flag shows that characters are waiting and that the line has been quiet for fifteen bit-times. An active-low request-to-send output lets the far end stop sending before the store fills.

Top module: `uart_rx_core`

## Requirements
- R1: The mode byte selects the frame format. Bit 6 set means 7 data bits, and then bit 7 of the stored byte is 0. Bit 5 enables parity. Bit 4 selects odd parity when set and even parity when clear. Bit 3 selects two stop bits. Data bits arrive least significant bit first.
- R2: A low level seen on a tick starts a character only if the line is still low 8 ticks later. A shorter low pulse is ignored and stores nothing. Every later bit is sampled once per 16 ticks.
- R3: When parity is enabled and the received parity bit does not match the selected parity, the stored entry carries `rd_perr` = 1. Otherwise `rd_perr` is 0.
- R4: When the first stop bit samples 0, the stored entry carries `rd_ferr` = 1. Only the first stop bit is checked.
- R5: The store holds up to 16 entries and returns them in arrival order at `rd_data`. A pop removes the head entry. `fill_cnt` gives the number of entries held.
- R6: A character that completes while 16 entries are held raises `overrun` for one cycle. That character is discarded, and the stored entries and the count stay unchanged.
- R7: A frame in which every sampled bit is 0 (start, data, parity when enabled, and first stop) raises `brk` for one cycle and stores nothing. No new character is started until the line has returned high.
- R8: `fifo_trig` is 1 exactly when `fill_cnt` is at least `trig_lvl`, where `trig_lvl` ranges from 1 to 16.
- R9: `data_ready` becomes 1 once the store is non-empty and no character has been stored for 240 ticks (15 bit-times). It drops as soon as the store becomes empty.
- R10: `rts_n` is 1 (do not send) while `fill_cnt` is 15 or more, and 0 below that.
- R11: After reset the store is empty, and `data_ready`, `fifo_trig`, `overrun`, `brk` and `rts_n` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| mode | input | 8 | Frame format: bit 6 = 7-bit, bit 5 = parity on, bit 4 = odd, bit 3 = 2 stop |
| trig_lvl | input | 5 | Fill threshold for `fifo_trig` |
| pop | input | 1 | Remove head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_ferr | output | 1 | Head entry framing error tag |
| fill_cnt | output | 5 | Entries currently held |
| fifo_trig | output | 1 | Fill count at or above threshold |
| data_ready | output | 1 | Data waiting and line idle for 15 bit-times |
| overrun | output | 1 | One-cycle pulse: character dropped on full store |
| brk | output | 1 | One-cycle pulse: break detected |
| rts_n | output | 1 | Active-low request to send, high at 15+ entries |

## Verification
The hardest situation to reach is an overrun. It needs sixteen complete, well-formed characters sent back to back with no pops in between, followed by a seventeenth character. After that, all sixteen entries must be drained to show that the dropped character did not disturb any stored one. The bench builds that sequence directly. Along the way it checks the threshold flag and the request-to-send output at the exact counts where each one changes. A break is produced by holding the line low for twice a frame length, which also shows that no false character starts before the line is released.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_entry_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic       len7,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push_o,
  output rx_entry_t  entry_o,
  output logic       brk_o
);

  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] T_FULL = TW'(OSR - 1);

  rx_state_e      st_q, st_d;
  logic [TW-1:0]  tcnt_q, tcnt_d;
  logic [2:0]     bidx_q, bidx_d;
  logic [7:0]     data_q, data_d;
  logic           pbit_q, pbit_d;
  logic           push_q, push_d;
  logic           brk_q, brk_d;
  logic           perr_q, perr_d;
  logic           ferr_q, ferr_d;
  logic [2:0]     last_idx;
  logic           all_zero;

  assign last_idx = len7 ? 3'd6 : 3'd7;
  assign all_zero = (data_q == 8'h00) && !(par_en && pbit_q) && !rx_s;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    data_d = data_q;
    pbit_d = pbit_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    push_d = 1'b0;
    brk_d  = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
        RX_START: begin
          if (tcnt_q == T_HALF) begin
            tcnt_d = '0;
            bidx_d = '0;
            data_d = '0;
            pbit_d = 1'b0;
            st_d   = rx_s ? RX_IDLE : RX_DATA;
          end else tcnt_d = tcnt_q + 1'b1;
        end
        RX_DATA: begin
          if (tcnt_q == T_FULL) begin
            tcnt_d         = '0;
            data_d[bidx_q] = rx_s;
            if (bidx_q == last_idx) st_d = par_en ? RX_PAR : RX_STOP;
            else bidx_d = bidx_q + 1'b1;
          end else tcnt_d = tcnt_q + 1'b1;
        end
        RX_PAR: begin
          if (tcnt_q == T_FULL) begin
            tcnt_d = '0;
            pbit_d = rx_s;
            st_d   = RX_STOP;
          end else tcnt_d = tcnt_q + 1'b1;
        end
        RX_STOP: begin
          if (tcnt_q == T_FULL) begin
            tcnt_d = '0;
            if (all_zero) begin
              brk_d = 1'b1;
              st_d  = RX_HOLD;
            end else begin
              push_d = 1'b1;
              ferr_d = !rx_s;
              perr_d = par_en & ((^data_q) ^ pbit_q ^ par_odd);
              st_d   = RX_IDLE;
            end
          end else tcnt_d = tcnt_q + 1'b1;
        end
        RX_HOLD: if (rx_s) st_d = RX_IDLE;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      data_q <= '0;
      pbit_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      push_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      data_q <= data_d;
      pbit_q <= pbit_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      push_q <= push_d;
      brk_q  <= brk_d;
    end
  end

  assign push_o  = push_q;
  assign brk_o   = brk_q;
  assign entry_o = '{data: data_q, perr: perr_q, ferr: ferr_q};

  // R2
  start_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA && $past(st_q) == RX_START) |-> !$past(rx_s));

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && $past(st_q) == RX_HOLD) |-> $past(rx_s));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  rx_entry_t                    wr_entry,
  input  logic                         pop,
  output rx_entry_t                    head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovr_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t      mem_q [DEPTH];
  logic [AW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ovr_q, ovr_d;
  logic           do_wr, do_rd;

  assign do_wr = push && (cnt_q != FULL_CNT);
  assign do_rd = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = do_wr ? wp_q + 1'b1 : wp_q;
    rp_d  = do_rd ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
    ovr_d = push && (cnt_q == FULL_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_entry;
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;
  assign ovr_o = ovr_q;

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == FULL_CNT && !pop) |=> ($stable(cnt_q) && ovr_q));

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int LIMIT = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) cnt_d = '0;
    else if (tick && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIM);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DEPTH     = 16,
  parameter int IDLE_BITS = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        rxd,
  input  logic [7:0]                  mode,
  input  logic [$clog2(DEPTH+1)-1:0]  trig_lvl,
  input  logic                        pop,
  output logic [7:0]                  rd_data,
  output logic                        rd_perr,
  output logic                        rd_ferr,
  output logic [$clog2(DEPTH+1)-1:0]  fill_cnt,
  output logic                        fifo_trig,
  output logic                        data_ready,
  output logic                        overrun,
  output logic                        brk,
  output logic                        rts_n
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] RTS_LVL = CW'(DEPTH - 1);

  logic [1:0]  sync_q;
  logic        push;
  rx_entry_t   new_entry, head;
  logic        idle_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rx_s    (sync_q[1]),
    .len7    (mode[6]),
    .par_en  (mode[5]),
    .par_odd (mode[4]),
    .push_o  (push),
    .entry_o (new_entry),
    .brk_o   (brk)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .wr_entry (new_entry),
    .pop      (pop),
    .head     (head),
    .count    (fill_cnt),
    .ovr_o    (overrun)
  );

  uart_rx_idle #(.LIMIT(IDLE_BITS * OSR)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (push),
    .expired (idle_exp)
  );

  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign fifo_trig  = (fill_cnt >= trig_lvl);
  assign data_ready = idle_exp && (fill_cnt != '0);
  assign rts_n      = (fill_cnt >= RTS_LVL);

  // R10
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(push));

  // R9
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> !$past(push));

  // R7
  brk_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (!push && $stable(fill_cnt)) || $past(pop));

endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] dat;
    logic       badp;
    logic       bads;
    logic [7:0] xd;
    logic       xp;
    logic       xf;
  } vec_t;

  // mode: bit6 7-bit, bit5 parity, bit4 odd, bit3 two stop
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{8'h20, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{8'h30, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{8'h20, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
    '{8'h30, 8'h07, 1'b1, 1'b0, 8'h07, 1'b1, 1'b0},
    '{8'h40, 8'h7F, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0},
    '{8'h40, 8'hC3, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0},
    '{8'h68, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    '{8'h00, 8'h12, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1},
    '{8'h28, 8'h12, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1},
    '{8'h08, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  localparam int BITCLK = 32;

  logic       clk, rst_n, tick, rxd, pop;
  logic [7:0] mode;
  logic [4:0] trig_lvl, fill_cnt;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, fifo_trig, data_ready, overrun, brk, rts_n;
  int         n_chk, n_fail, ovr_seen, brk_seen;

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode),
    .trig_lvl(trig_lvl), .pop(pop), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .fill_cnt(fill_cnt), .fifo_trig(fifo_trig),
    .data_ready(data_ready), .overrun(overrun), .brk(brk), .rts_n(rts_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  always @(negedge clk) begin
    if (overrun) ovr_seen++;
    if (brk) brk_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] m, input logic [7:0] d,
                           input logic bp, input logic bs);
    int nb;
    logic p;
    nb = m[6] ? 7 : 8;
    p  = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i]);
      p ^= d[i];
    end
    if (m[5]) send_bit(p ^ m[4] ^ bp);
    send_bit(~bs);
    if (m[3]) send_bit(1'b1);
    rxd = 1'b1;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; ovr_seen = 0; brk_seen = 0;
    rst_n = 1'b0; rxd = 1'b1; pop = 1'b0; mode = 8'h00; trig_lvl = 5'd4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check(fill_cnt == 0, "R11 fill", fill_cnt, 0);
    check(!data_ready && !fifo_trig, "R11 flags", {data_ready, fifo_trig}, 0);
    check(!overrun && !brk && !rts_n, "R11 pulses/rts", {overrun, brk, rts_n}, 0);

    // R1 R3 R4: format table
    foreach (VEC[k]) begin
      mode = VEC[k].mode;
      idle_bits(1);
      send_char(VEC[k].mode, VEC[k].dat, VEC[k].badp, VEC[k].bads);
      idle_bits(2);
      check(fill_cnt == 1, "R1 char stored", fill_cnt, 1);
      check(rd_data == VEC[k].xd, "R1 data", rd_data, VEC[k].xd);
      check(rd_perr == VEC[k].xp, "R3 parity tag", rd_perr, VEC[k].xp);
      check(rd_ferr == VEC[k].xf, "R4 framing tag", rd_ferr, VEC[k].xf);
      do_pop();
    end

    // R2 short low pulse is rejected
    mode = 8'h00;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    idle_bits(3);
    check(fill_cnt == 0, "R2 glitch ignored", fill_cnt, 0);

    // R9 data-ready timeout
    send_char(8'h00, 8'h33, 1'b0, 1'b0);
    idle_bits(12);
    check(!data_ready, "R9 not yet ready", data_ready, 0);
    idle_bits(4);
    check(data_ready, "R9 ready after timeout", data_ready, 1);
    do_pop();
    check(!data_ready, "R9 ready drops when empty", data_ready, 0);

    // R5 R8 R10 fill
    trig_lvl = 5'd8;
    for (int i = 0; i < 16; i++) begin
      idle_bits(1);
      send_char(8'h00, 8'(8'h40 + i), 1'b0, 1'b0);
      if (i == 6)  check(!fifo_trig, "R8 below trigger", fifo_trig, 0);
      if (i == 7)  check(fifo_trig, "R8 at trigger", fifo_trig, 1);
      if (i == 13) check(!rts_n, "R10 rts at 14", rts_n, 0);
      if (i == 14) check(rts_n, "R10 rts at 15", rts_n, 1);
    end
    check(fill_cnt == 16, "R5 full count", fill_cnt, 16);
    check(ovr_seen == 0, "R6 no early overrun", ovr_seen, 0);

    // R6 overrun
    idle_bits(1);
    send_char(8'h00, 8'hEE, 1'b0, 1'b0);
    idle_bits(1);
    check(ovr_seen == 1, "R6 overrun pulse", ovr_seen, 1);
    check(fill_cnt == 16, "R6 count kept", fill_cnt, 16);

    for (int i = 0; i < 16; i++) begin
      check(rd_data == 8'(8'h40 + i), "R5 order / R6 contents", rd_data, 8'h40 + i);
      do_pop();
      if (i == 0) check(rts_n, "R10 rts at 15 draining", rts_n, 1);
      if (i == 1) check(!rts_n, "R10 rts below 15", rts_n, 0);
    end
    check(fill_cnt == 0, "R5 drained", fill_cnt, 0);

    // R7 break
    rxd = 1'b0;
    repeat (20 * BITCLK) @(negedge clk);
    check(brk_seen == 1, "R7 break pulse", brk_seen, 1);
    check(fill_cnt == 0, "R7 nothing stored", fill_cnt, 0);
    idle_bits(2);
    send_char(8'h00, 8'h5A, 1'b0, 1'b0);
    idle_bits(1);
    check(fill_cnt == 1 && rd_data == 8'h5A, "R7 resume after high", rd_data, 8'h5A);
    check(brk_seen == 1, "R7 single pulse", brk_seen, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule